// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is a synthesizable stand-in for a 4 Kbit serial EEPROM with a chip-select, serial clock, serial data-in and a releasable data-out line. It runs entirely on a fast system clock. The three serial pins are synchronised and edge-detected, and then a small controller shifts in a start bit, a two-bit opcode, an address and, for programming commands, a data word. A word-size input picks one of two organisations of the same 512-byte register array: sixteen-bit words or bytes.

Reads stream words out on the data-out line, after a single leading zero bit, for as long as chip-select stays high. Programming commands (word write, word erase, whole-array erase, whole-array write) are guarded by a write-enable latch. They are launched when chip-select drops after the final required bit. A self-timed busy period follows, counted in system clocks. While it runs, raising chip-select again shows busy (0) or ready (1) on the data-out line.

Top module: `mw_eeprom_slave`

## Requirements
- R1: An instruction begins at the first serial-clock rising edge that sees chip-select and data-in both high. Rising edges with data-in low before that point change nothing.
- R2: The two bits after the start select the command: 10 read, 01 word write, 11 word erase. For 00, the first two address bits received choose the command: 11 enables programming, 00 disables it, 10 erases the whole array, 01 writes the whole array.
- R3: With the word-size input high, words are 16 bits and addresses 8 bits, and word a is byte 2a (upper half) joined with byte 2a+1 (lower half). With it low, words are bytes and addresses are 9 bits. After reset every byte reads 0xFF.
- R4: After the last read-address bit, data-out is driven and shows 0. Each further serial-clock rising edge presents the next data bit, most significant first.
- R5: While chip-select stays high, a read continues with the following address. The address wraps to 0 after the last word of the current organisation.
- R6: Programming is disabled after reset. Write, erase, whole-array erase and whole-array write leave the array unchanged and start no busy period unless the enable command has run since the last disable command. Read works in either state.
- R7: Word erase and whole-array erase set bits to 1. Word write stores the shifted-in word. Whole-array write stores the shifted-in word at every address.
- R8: A command takes effect on the chip-select fall that follows its final required bit. If chip-select falls earlier, the command is dropped.
- R9: Data-out is released whenever chip-select is low. When chip-select is raised after a programming command has started, data-out drives 0 while the busy period runs and 1 once it has ended.
- R10: Data-out stays released while chip-select is held low during a busy period. A start bit followed by a chip-select fall clears the ready indication, and data-out then stays released on the next chip-select high.
- R11: A start bit arriving during a busy period is ignored, and data-out keeps showing the busy/ready flag.
- R12: The busy period lasts T_WORD system clocks for single-word commands and T_ALL system clocks for whole-array commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Chip-select, active high, asynchronous to clk |
| sck | input | 1 | Serial clock, asynchronous to clk |
| sdi | input | 1 | Serial data in |
| org | input | 1 | Word size: 1 = 16-bit words, 0 = bytes |
| sdo_d | output | 1 | Serial data-out value |
| sdo_oe | output | 1 | Data-out drive enable; 0 means the line is released (high impedance) |

## Verification
The hardest state to reach is a start bit arriving during a busy period with chip-select high. It needs a whole-array write to be launched and chip-select raised again inside the busy window, and then a complete read header clocked in before the timer expires. The bench shortens both program durations through parameters so this fits. It then checks that data-out still shows busy, and later ready, rather than a dummy zero. Truncated instructions and reads that wrap past the last address in both organisations are also driven, and every word is compared with a byte-level reference model kept in the bench.

// File: rtl/mw_pkg.sv
package mw_pkg;

    localparam int unsigned ADDR_W = 9;   // byte address width
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned WORD_W = 2 * BYTE_W;
    localparam int unsigned CNT_W  = 5;

    typedef enum logic [2:0] {
        CMD_READ, CMD_WRITE, CMD_ERASE, CMD_WEN,
        CMD_WDIS, CMD_ERASE_ALL, CMD_WRITE_ALL
    } cmd_e;

    typedef enum logic [2:0] {
        ST_WAIT, ST_OPC, ST_ADDR, ST_DATA, ST_READ, ST_HOLD
    } st_e;

    typedef struct packed {
        cmd_e                cmd;
        logic [ADDR_W-1:0]   addr;
        logic [WORD_W-1:0]   data;
    } req_t;

    function automatic cmd_e decode_cmd(input logic [1:0] opc, input logic [1:0] hi);
        cmd_e c;
        case (opc)
            2'b10:   c = CMD_READ;
            2'b01:   c = CMD_WRITE;
            2'b11:   c = CMD_ERASE;
            default: begin
                case (hi)
                    2'b11:   c = CMD_WEN;
                    2'b00:   c = CMD_WDIS;
                    2'b10:   c = CMD_ERASE_ALL;
                    default: c = CMD_WRITE_ALL;
                endcase
            end
        endcase
        return c;
    endfunction

    function automatic logic is_prog(input cmd_e c);
        return (c == CMD_WRITE) || (c == CMD_ERASE) ||
               (c == CMD_ERASE_ALL) || (c == CMD_WRITE_ALL);
    endfunction

    function automatic logic takes_data(input cmd_e c);
        return (c == CMD_WRITE) || (c == CMD_WRITE_ALL);
    endfunction

endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
    parameter int unsigned N      = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    for (genvar b = 0; b < N; b++) begin : g_pin
        logic [STAGES:0] sh_q;
        always_ff @(posedge clk) begin
            if (rst) sh_q <= '0;
            else     sh_q <= {sh_q[STAGES-1:0], raw[b]};
        end
        assign lvl[b]  = sh_q[STAGES-1];
        assign rise[b] = sh_q[STAGES-1] & ~sh_q[STAGES];
        assign fall[b] = ~sh_q[STAGES-1] & sh_q[STAGES];
    end
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
    parameter int unsigned T_WORD = 20000,
    parameter int unsigned T_ALL  = 60000
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic whole,
    output logic busy
);
    localparam int unsigned TMAX = (T_ALL > T_WORD) ? T_ALL : T_WORD;
    localparam int unsigned CW   = $clog2(TMAX + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (go)            cnt_q <= whole ? CW'(T_ALL) : CW'(T_WORD);
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);

    // R12: a new program cycle is only launched from idle
    p_go_from_idle_r12: assert property (@(posedge clk) disable iff (rst)
        go |-> !busy);

    // R12: once running, busy stays up until the count drains
    p_busy_persists_r12: assert property (@(posedge clk) disable iff (rst)
        (busy && !go && cnt_q > CW'(1)) |=> busy);
endmodule

// File: rtl/mw_array.sv
module mw_array import mw_pkg::*; #(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned BW = BYTE_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            org,
    input  logic            wr_go,
    input  logic            wr_all,
    input  logic [AW-1:0]   wr_addr,
    input  logic [2*BW-1:0] wr_data,
    input  logic [AW-1:0]   rd_addr,
    output logic [2*BW-1:0] rd_word
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [BW-1:0]    mem [DEPTH];
    logic [DEPTH-1:0] hit;

    for (genvar i = 0; i < DEPTH; i++) begin : g_hit
        localparam logic [AW-1:0] IDX = AW'(i);
        assign hit[i] = wr_all ||
                        (org ? (wr_addr[AW-2:0] == IDX[AW-1:1]) : (wr_addr == IDX));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (wr_go) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (hit[i]) mem[i] <= (org && (i % 2 == 0)) ? wr_data[2*BW-1:BW]
                                                             : wr_data[BW-1:0];
            end
        end
    end

    always_comb begin
        if (org) rd_word = {mem[{rd_addr[AW-2:0], 1'b0}], mem[{rd_addr[AW-2:0], 1'b1}]};
        else     rd_word = {{BW{1'b0}}, mem[rd_addr]};
    end
endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave import mw_pkg::*; #(
    parameter int unsigned T_WORD      = 20000,
    parameter int unsigned T_ALL       = 60000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sel,
    input  logic sck,
    input  logic sdi,
    input  logic org,
    output logic sdo_d,
    output logic sdo_oe
);
    localparam logic [CNT_W-1:0] AW_X8  = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0] AW_X16 = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] DW_X8  = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] DW_X16 = CNT_W'(WORD_W);

    // pin synchronisation
    logic [2:0] pin_lvl, pin_rise, pin_fall;
    logic       cs_s, cs_fall, sck_rise, di_s;
    logic       unused_edges;

    mw_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .raw  ({sel, sck, sdi}),
        .lvl  (pin_lvl),
        .rise (pin_rise),
        .fall (pin_fall)
    );

    assign cs_s         = pin_lvl[2];
    assign cs_fall      = pin_fall[2];
    assign sck_rise     = pin_rise[1];
    assign di_s         = pin_lvl[0];
    assign unused_edges = ^{pin_rise[2], pin_rise[0], pin_fall[1:0], pin_lvl[1]};

    // controller state
    st_e                st_q;
    req_t               req_q;
    logic [1:0]         opc_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   rleft_q;
    logic               first_q;
    logic [WORD_W-1:0]  sreg_q;
    logic               wen_q;
    logic               stat_q;
    logic               oe_q, do_q;

    logic [CNT_W-1:0]   cur_aw, cur_dw;
    logic [ADDR_W-1:0]  addr_nxt, addr_inc, rd_ptr;
    logic [1:0]         hi2;
    cmd_e               dec_cmd;
    logic [WORD_W-1:0]  rd_word, ld_word;
    logic               busy, prog_go, prog_all;
    logic [WORD_W-1:0]  wr_data;

    assign cur_aw   = org ? AW_X16 : AW_X8;
    assign cur_dw   = org ? DW_X16 : DW_X8;
    assign addr_nxt = {req_q.addr[ADDR_W-2:0], di_s};
    assign hi2      = org ? addr_nxt[ADDR_W-2 -: 2] : addr_nxt[ADDR_W-1 -: 2];
    assign dec_cmd  = decode_cmd(opc_q, hi2);
    assign addr_inc = org ? {1'b0, req_q.addr[ADDR_W-2:0] + 1'b1} : req_q.addr + 1'b1;
    assign rd_ptr   = first_q ? req_q.addr : addr_inc;
    assign ld_word  = org ? rd_word : {rd_word[BYTE_W-1:0], {BYTE_W{1'b0}}};

    assign prog_go  = cs_fall && (st_q == ST_HOLD) && wen_q && is_prog(req_q.cmd);
    assign prog_all = (req_q.cmd == CMD_ERASE_ALL) || (req_q.cmd == CMD_WRITE_ALL);
    assign wr_data  = ((req_q.cmd == CMD_ERASE) || (req_q.cmd == CMD_ERASE_ALL))
                      ? '1 : req_q.data;

    mw_array #(.AW(ADDR_W), .BW(BYTE_W)) u_array (
        .clk     (clk),
        .rst     (rst),
        .org     (org),
        .wr_go   (prog_go),
        .wr_all  (prog_all),
        .wr_addr (req_q.addr),
        .wr_data (wr_data),
        .rd_addr (rd_ptr),
        .rd_word (rd_word)
    );

    mw_prog_timer #(.T_WORD(T_WORD), .T_ALL(T_ALL)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .go    (prog_go),
        .whole (prog_all),
        .busy  (busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_WAIT;
            req_q   <= '{cmd: CMD_READ, addr: '0, data: '0};
            opc_q   <= '0;
            cnt_q   <= '0;
            rleft_q <= '0;
            first_q <= 1'b0;
            sreg_q  <= '0;
            wen_q   <= 1'b0;
            stat_q  <= 1'b0;
            oe_q    <= 1'b0;
            do_q    <= 1'b0;
        end else if (!cs_s) begin
            st_q <= ST_WAIT;
            oe_q <= 1'b0;
            if (cs_fall && st_q == ST_HOLD) begin
                if (req_q.cmd == CMD_WEN)  wen_q <= 1'b1;
                if (req_q.cmd == CMD_WDIS) wen_q <= 1'b0;
                if (prog_go)               stat_q <= 1'b1;
            end
        end else begin
            case (st_q)
                ST_WAIT: begin
                    oe_q <= stat_q;
                    do_q <= !busy;
                    if (sck_rise && di_s && !busy) begin
                        stat_q     <= 1'b0;
                        oe_q       <= 1'b0;
                        st_q       <= ST_OPC;
                        cnt_q      <= '0;
                        req_q.addr <= '0;
                        req_q.data <= '0;
                    end
                end
                ST_OPC: if (sck_rise) begin
                    opc_q <= {opc_q[0], di_s};
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == CNT_W'(1)) begin
                        st_q  <= ST_ADDR;
                        cnt_q <= '0;
                    end
                end
                ST_ADDR: if (sck_rise) begin
                    req_q.addr <= addr_nxt;
                    cnt_q      <= cnt_q + 1'b1;
                    if (cnt_q == cur_aw - 1'b1) begin
                        req_q.cmd <= dec_cmd;
                        cnt_q     <= '0;
                        if (dec_cmd == CMD_READ) begin
                            st_q    <= ST_READ;
                            oe_q    <= 1'b1;
                            do_q    <= 1'b0;
                            rleft_q <= '0;
                            first_q <= 1'b1;
                        end else if (takes_data(dec_cmd)) begin
                            st_q <= ST_DATA;
                        end else begin
                            st_q <= ST_HOLD;
                        end
                    end
                end
                ST_DATA: if (sck_rise) begin
                    req_q.data <= {req_q.data[WORD_W-2:0], di_s};
                    cnt_q      <= cnt_q + 1'b1;
                    if (cnt_q == cur_dw - 1'b1) st_q <= ST_HOLD;
                end
                ST_READ: if (sck_rise) begin
                    if (rleft_q == '0) begin
                        do_q       <= ld_word[WORD_W-1];
                        sreg_q     <= ld_word << 1;
                        rleft_q    <= cur_dw - 1'b1;
                        first_q    <= 1'b0;
                        req_q.addr <= rd_ptr;
                    end else begin
                        do_q    <= sreg_q[WORD_W-1];
                        sreg_q  <= sreg_q << 1;
                        rleft_q <= rleft_q - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign sdo_d  = do_q;
    assign sdo_oe = oe_q;

    // R9: data-out is released one cycle after chip-select is seen low
    p_release_deselect_r9: assert property (@(posedge clk) disable iff (rst)
        !cs_s |=> !sdo_oe);

    // R11: the shifter never leaves the wait state while programming runs
    p_start_blocked_busy_r11: assert property (@(posedge clk) disable iff (rst)
        busy |-> (st_q == ST_WAIT));

    // R6: a program cycle only begins with the enable latch set
    p_prog_needs_enable_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wen_q));

    // R4: the first bit driven by a read is the dummy zero
    p_dummy_zero_r4: assert property (@(posedge clk) disable iff (rst)
        ($rose(sdo_oe) && st_q == ST_READ) |-> !sdo_d);

    // R9: data-out is only driven for a read or a pending status flag
    p_drive_reason_r9: assert property (@(posedge clk) disable iff (rst)
        sdo_oe |-> (st_q == ST_READ || stat_q));
endmodule

// File: tb/mw_eeprom_slave_tb.sv
module mw_eeprom_slave_tb;
    localparam int T_WORD = 60;
    localparam int T_ALL  = 200;

    logic clk = 1'b0, rst = 1'b1;
    logic sel = 1'b0, sck = 1'b0, sdi = 1'b0, org = 1'b1;
    logic sdo_d, sdo_oe;

    always #4 clk = ~clk;   // 125 MHz

    mw_eeprom_slave #(.T_WORD(T_WORD), .T_ALL(T_ALL)) u_dut (
        .clk(clk), .rst(rst), .sel(sel), .sck(sck), .sdi(sdi), .org(org),
        .sdo_d(sdo_d), .sdo_oe(sdo_oe)
    );

    int   n_chk = 0, n_err = 0;
    bit   finished = 0;
    logic [7:0] ref_mem [512];
    bit   ref_wen = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int aw();
        return org ? 8 : 9;
    endfunction
    function automatic int dw();
        return org ? 16 : 8;
    endfunction
    function automatic logic [15:0] exp_word(input int a);
        logic [8:0] ia = 9'(a);
        if (org) return {ref_mem[{ia[7:0], 1'b0}], ref_mem[{ia[7:0], 1'b1}]};
        return {8'h00, ref_mem[ia]};
    endfunction

    // reference model of a completed programming command
    task automatic ref_prog(input int kind, input int a, input logic [15:0] d);
        logic [8:0] ia = 9'(a);
        if (!ref_wen) return;
        if (kind == 2 || kind == 3) begin   // whole array: 2 erase, 3 write
            for (int i = 0; i < 512; i++)
                ref_mem[i] = (kind == 2) ? 8'hFF : ((org && i % 2 == 0) ? d[15:8] : d[7:0]);
        end else begin                      // 0 write, 1 erase
            logic [15:0] v = (kind == 1) ? 16'hFFFF : d;
            if (org) begin
                ref_mem[{ia[7:0], 1'b0}] = v[15:8];
                ref_mem[{ia[7:0], 1'b1}] = v[7:0];
            end else ref_mem[ia] = v[7:0];
        end
    endtask

    task automatic settle();
        @(negedge clk);
    endtask
    task automatic bit_out(input logic b);
        sdi = b;
        repeat (3) @(posedge clk);
        sck = 1'b1;
        repeat (4) @(posedge clk);
        sck = 1'b0;
        repeat (4) @(posedge clk);
    endtask
    task automatic cs_on();
        sel = 1'b1;
        repeat (6) @(posedge clk);
    endtask
    task automatic cs_off();
        sel = 1'b0;
        sdi = 1'b0;
        repeat (8) @(posedge clk);
    endtask
    task automatic shift(input logic [63:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) bit_out(v[i]);
    endtask

    // start + opcode + address (+ data), dropping 'trim' final bits
    task automatic send(input logic [1:0] opc, input int a, input logic [15:0] d,
                        input bit with_data, input int trim);
        logic [63:0] v = {61'b0, 1'b1, opc};
        int len = 3 + aw();
        v = (v << aw()) | 64'(a);
        if (with_data) begin
            v = (v << dw()) | 64'(d);
            len += dw();
        end
        cs_on();
        shift(v >> trim, len - trim);
    endtask

    task automatic ctrl(input logic [1:0] top2);
        send(2'b00, int'(top2) << (aw() - 2), 16'h0, 1'b0, 0);
        cs_off();
        if (top2 == 2'b11) ref_wen = 1;
        if (top2 == 2'b00) ref_wen = 0;
    endtask

    task automatic prog_wait(input int cycles);
        cs_off();
        repeat (cycles + 20) @(posedge clk);
    endtask

    task automatic read_seq(input int a, input int n, input string req);
        int mask = org ? 255 : 511;
        cs_on();
        shift(64'd0, 3);             // R1: clocks with data-in low before start
        shift(64'b110, 3);
        shift(64'(a), aw());
        settle();
        check({req, " R4 dummy zero"}, {30'b0, sdo_oe, sdo_d}, 32'h2);
        for (int w = 0; w < n; w++) begin
            logic [15:0] got = '0;
            for (int b = 0; b < dw(); b++) begin
                bit_out(1'b0);
                settle();
                got = {got[14:0], sdo_d};
            end
            check({req, " R5 word"}, {15'b0, sdo_oe, got}, {15'b0, 1'b1, exp_word((a + w) & mask)});
        end
        cs_off();
    endtask

    initial begin
        for (int i = 0; i < 512; i++) ref_mem[i] = 8'hFF;
        repeat (5) @(posedge clk);
        rst = 1'b0;
        repeat (3) @(posedge clk);
        settle();
        check("R9 reset released", {31'b0, sdo_oe}, 32'h0);

        // R3 reset contents, R4 read framing
        read_seq(5, 1, "R3");

        // R6: write while disabled has no effect, no status
        send(2'b01, 3, 16'hA5C3, 1'b1, 0);
        ref_prog(0, 3, 16'hA5C3);
        cs_off();
        cs_on();
        settle();
        check("R6 no busy when disabled", {31'b0, sdo_oe}, 32'h0);
        cs_off();
        read_seq(3, 1, "R6");

        // R2 enable, R9/R10/R12 status sequence
        ctrl(2'b11);
        send(2'b01, 3, 16'hA5C3, 1'b1, 0);
        ref_prog(0, 3, 16'hA5C3);
        cs_off();
        settle();
        check("R10 released while busy and deselected", {31'b0, sdo_oe}, 32'h0);
        cs_on();
        settle();
        check("R9 busy flag", {30'b0, sdo_oe, sdo_d}, 32'h2);
        repeat (T_WORD - 20) @(posedge clk);
        settle();
        check("R12 still busy near T_WORD", {30'b0, sdo_oe, sdo_d}, 32'h2);
        repeat (20) @(posedge clk);
        settle();
        check("R12 ready after T_WORD", {30'b0, sdo_oe, sdo_d}, 32'h3);
        bit_out(1'b1);
        cs_off();
        cs_on();
        settle();
        check("R10 status cleared", {31'b0, sdo_oe}, 32'h0);
        cs_off();

        // R7 write, R5 sequential read
        send(2'b01, 4, 16'h0F1E, 1'b1, 0);
        ref_prog(0, 4, 16'h0F1E);
        prog_wait(T_WORD);
        read_seq(3, 2, "R7");

        // R3 byte view of the same array, x8 write
        org = 1'b0;
        read_seq(6, 2, "R3");
        send(2'b01, 9, 16'h003C, 1'b1, 0);
        ref_prog(0, 9, 16'h003C);
        prog_wait(T_WORD);
        read_seq(8, 2, "R3");
        read_seq(511, 2, "R5 wrap x8");

        // R7 erase in x16
        org = 1'b1;
        send(2'b11, 3, 16'h0, 1'b0, 0);
        ref_prog(1, 3, 16'h0);
        prog_wait(T_WORD);
        read_seq(3, 1, "R7");

        // R8 truncated write dropped
        send(2'b01, 2, 16'h1357, 1'b1, 1);
        cs_off();
        cs_on();
        settle();
        check("R8 truncated starts nothing", {31'b0, sdo_oe}, 32'h0);
        cs_off();
        read_seq(2, 1, "R8");

        // R2 whole-array write, R11 start during busy
        ctrl(2'b01 /* placeholder overwritten below */);
        send(2'b00, 1 << (aw() - 2), 16'h1234, 1'b1, 0);
        ref_prog(3, 0, 16'h1234);
        cs_off();
        cs_on();
        shift(64'b110, 3);
        shift(64'd0, 8);
        settle();
        check("R11 start ignored while busy", {30'b0, sdo_oe, sdo_d}, 32'h2);
        repeat (T_ALL) @(posedge clk);
        settle();
        check("R11 R12 ready after T_ALL", {30'b0, sdo_oe, sdo_d}, 32'h3);
        cs_off();
        read_seq(254, 3, "R7 R5 wrap x16");

        // R7 whole-array erase
        ctrl(2'b10);
        ref_prog(2, 0, 16'h0);
        repeat (T_ALL + 20) @(posedge clk);
        read_seq(7, 1, "R7");

        // R6 disable again
        ctrl(2'b00);
        send(2'b01, 7, 16'h5555, 1'b1, 0);
        ref_prog(0, 7, 16'h5555);
        cs_off();
        cs_on();
        settle();
        check("R6 disabled again", {31'b0, sdo_oe}, 32'h0);
        cs_off();
        read_seq(7, 1, "R6");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule